// File: doc/BRIEF.md
# eMMC Command and Response Engine

This block issues one command at a time to an eMMC device and collects the device's answer. Software on the system clock loads a 6-bit command index, a 32-bit argument and a response kind, then pulses `start`. The engine runs on its own card clock, which may be fully asynchronous to the system clock and is always slower than it. It serialises a 48-bit frame with its CRC-7 onto the CMD line. It then waits for the device's start bit and shifts in a short (48-bit) or long (136-bit) response. When no start bit arrives in time, it gives up with a timeout.

Every received response is checked with CRC-7, including response types whose CRC field carries no meaning. Software therefore sees a sticky CRC error flag after such responses and clears it itself. The response is copied into two 64-bit response registers on the system side. The level of DAT0 is brought to the system clock so that software can poll the busy phase that follows a response with busy. Requests and completions cross between the two clocks as level toggles through synchronisers. One accepted request therefore produces exactly one frame and one completion.

Top module: `emmc_cmd_engine`

## Requirements
- R1: After an accepted start, `cmd_oe` is high for exactly 48 engine clocks. During them `cmd_o` sends, most significant bit first: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a 7-bit CRC and a 1 end bit. The CRC uses x^7+x^3+1 with a zero seed and covers the first 40 bits. For index 0 and argument 0 the last frame byte is 0x95.
- R2: `busy` rises on the sys_clk edge that accepts `start` and falls after the completion arrives. A `start` pulse while `busy` is high is ignored, so one accepted start yields exactly one frame.
- R3: `resp_kind` selects the response: 0 or 3 means none, and completion follows the frame directly. 1 means a 48-bit response and 2 means a 136-bit response. In both of those cases the engine waits for a 0 on `cmd_in` and then samples the response, start bit included, on consecutive engine clock rising edges.
- R4: After a short response, `resp0` holds the 48 received frame bits in its low bits with zeros above, and `resp1` is zero. After a long response, `resp1` holds frame bits 127:64 and `resp0` holds frame bits 63:0.
- R5: The CRC-7 is computed over frame bits 47:8 of a short response or 127:8 of a long one and compared with frame bits 7:1. On a mismatch, `status[1]` is set and `status[2]` reads 0. On a match, `status[2]` reads 1.
- R6: A response whose CRC field is fixed ones, with reserved ones in place of the index, is still checked and flagged. `status[1]` stays set across later completions until software writes 1 to `flag_clr[1]`.
- R7: If no start bit is seen within 64 engine clocks after the frame, `status[3]` is set and the response registers and `status[2]` keep their previous values.
- R8: `status[0]` is set on each completion. Writing 1 to `flag_clr[0]`, `flag_clr[1]` or `flag_clr[3]` clears the matching status bit.
- R9: `dat0_level` follows `dat0_in` within three sys_clk cycles, so software can poll the busy phase.
- R10: After reset, `status`, `busy`, `cmd_oe`, `resp0` and `resp1` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, faster than the engine clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| emmc_clk | input | 1 | Engine clock, asynchronous to sys_clk |
| emmc_rst | input | 1 | Synchronous active-high reset, engine domain |
| cmd_index | input | 6 | Command index to send |
| cmd_arg | input | 32 | Command argument to send |
| resp_kind | input | 2 | Response kind: 0/3 none, 1 short, 2 long |
| start | input | 1 | One-cycle request to issue a command |
| flag_clr | input | 4 | Write-1-to-clear for status bits 0, 1 and 3 |
| busy | output | 1 | Command in progress |
| status | output | 4 | Bit 0 done, bit 1 CRC error flag, bit 2 CRC good, bit 3 timeout |
| resp0 | output | 64 | Low response register |
| resp1 | output | 64 | High response register |
| dat0_level | output | 1 | DAT0 level synchronised to sys_clk |
| cmd_in | input | 1 | CMD line as driven by the device |
| dat0_in | input | 1 | DAT0 line as driven by the device |
| cmd_o | output | 1 | CMD line value driven by the engine |
| cmd_oe | output | 1 | CMD line drive enable |

## Verification
The assertions check on every cycle that each frame opens with a 0 start bit and closes with a 1 end bit. They also check that a request never reaches the engine outside its idle state and that a completion only arrives while `busy` is high. Further cycle checks cover the CRC flag rising only together with a low CRC-good bit, the flag staying set until it is cleared, and a timeout never coinciding with a captured response. The frame content and CRC values, the register layout for short and long responses, and the stickiness across several commands can only be shown by the bench's scenarios. The same holds for the timeout window, the rejected second start and the DAT0 polling, since each depends on a sequence of commands and device replies.

// File: rtl/emmc_cmd_pkg.sv
package emmc_cmd_pkg;
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int RESP_W     = 64;
  localparam int KEEP_W     = 2 * RESP_W;

  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_SHORT = 2'd1;
  localparam logic [1:0] KIND_LONG  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_DONE
  } eng_state_e;

  // one bit of the x^7 + x^3 + 1 division, MSB first
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_head(input logic [39:0] d);
    logic [6:0] c;
    c = 7'h00;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/emmc_bit_sync.sv
module emmc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/emmc_cmd_core.sv
module emmc_cmd_core
  import emmc_cmd_pkg::*;
#(
  parameter int TO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_lvl,
  input  logic [5:0]        idx,
  input  logic [31:0]       arg,
  input  logic [1:0]        kind,
  input  logic              cmd_in,
  output logic              cmd_o,
  output logic              cmd_oe,
  output logic              done_tgl,
  output logic              got_resp,
  output logic              crc_match,
  output logic              timed_out,
  output logic [KEEP_W-1:0] rx_sh
);
  localparam int TOW = (TO_CYC > 2) ? $clog2(TO_CYC) : 1;
  localparam logic [TOW-1:0] TO_LAST = TOW'(TO_CYC - 1);
  localparam logic [TOW-1:0] W_ONE   = TOW'(1);
  localparam logic [7:0]     SH_LAST = 8'(FRAME_BITS - 1);
  localparam logic [7:0]     LG_LAST = 8'(LONG_BITS - 1);

  eng_state_e st;
  logic       req_prev;
  logic       req_edge;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [7:0]  cnt;
  logic [TOW-1:0] wcnt;
  logic [6:0]  rx_crc;
  logic [1:0]  kind_q;
  logic        want_resp;
  logic [7:0]  last_idx;
  logic        in_crc;

  assign req_edge  = req_lvl ^ req_prev;
  assign want_resp = (kind_q == KIND_SHORT) || (kind_q == KIND_LONG);
  assign last_idx  = (kind_q == KIND_LONG) ? LG_LAST : SH_LAST;
  assign in_crc    = (kind_q == KIND_LONG) ? (cnt >= 8'd8 && cnt < 8'd128)
                                           : (cnt < 8'd40);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_prev  <= 1'b0;
      cmd_o     <= 1'b1;
      cmd_oe    <= 1'b0;
      done_tgl  <= 1'b0;
      got_resp  <= 1'b0;
      crc_match <= 1'b0;
      timed_out <= 1'b0;
      tx_sh     <= '0;
      cnt       <= '0;
      wcnt      <= '0;
      rx_sh     <= '0;
      rx_crc    <= '0;
      kind_q    <= KIND_NONE;
    end else begin
      req_prev <= req_lvl;
      case (st)
        ST_IDLE: begin
          cmd_oe <= 1'b0;
          cmd_o  <= 1'b1;
          if (req_edge) begin
            tx_sh     <= {2'b01, idx, arg, crc7_head({2'b01, idx, arg}), 1'b1};
            kind_q    <= kind;
            cnt       <= '0;
            got_resp  <= 1'b0;
            timed_out <= 1'b0;
            st        <= ST_SEND;
          end
        end
        ST_SEND: begin
          cmd_oe <= 1'b1;
          cmd_o  <= tx_sh[FRAME_BITS-1];
          tx_sh  <= {tx_sh[FRAME_BITS-2:0], 1'b0};
          cnt    <= cnt + 8'd1;
          if (cnt == SH_LAST) begin
            cnt  <= '0;
            wcnt <= '0;
            st   <= want_resp ? ST_WAIT : ST_DONE;
          end
        end
        ST_WAIT: begin
          cmd_oe <= 1'b0;
          cmd_o  <= 1'b1;
          if (!cmd_in) begin
            rx_sh  <= '0;
            rx_crc <= '0;
            cnt    <= 8'd1;
            st     <= ST_RECV;
          end else if (wcnt == TO_LAST) begin
            timed_out <= 1'b1;
            st        <= ST_DONE;
          end else begin
            wcnt <= wcnt + W_ONE;
          end
        end
        ST_RECV: begin
          rx_sh <= {rx_sh[KEEP_W-2:0], cmd_in};
          if (in_crc) rx_crc <= crc7_step(rx_crc, cmd_in);
          cnt <= cnt + 8'd1;
          if (cnt == last_idx) begin
            got_resp <= 1'b1;
            st       <= ST_DONE;
          end
        end
        ST_DONE: begin
          cmd_oe    <= 1'b0;
          crc_match <= (rx_crc == rx_sh[7:1]);
          done_tgl  <= ~done_tgl;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_FRAME_START: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe) |-> (cmd_o == 1'b0)); // R1
  AST_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe) |-> $past(cmd_o)); // R1
  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_edge |-> (st == ST_IDLE)); // R2
  AST_TIMEOUT_NO_RESP: assert property (@(posedge clk) disable iff (rst)
    $rose(timed_out) |-> !got_resp); // R7
endmodule

// File: rtl/emmc_cmd_regs.sv
module emmc_cmd_regs
  import emmc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        cmd_index,
  input  logic [31:0]       cmd_arg,
  input  logic [1:0]        resp_kind,
  input  logic              start,
  input  logic [3:0]        flag_clr,
  input  logic              done_lvl,
  input  logic              got_resp,
  input  logic              crc_match,
  input  logic              timed_out,
  input  logic [KEEP_W-1:0] rx_frame,
  output logic              req_tgl,
  output logic [5:0]        idx_q,
  output logic [31:0]       arg_q,
  output logic [1:0]        kind_q,
  output logic              busy,
  output logic [3:0]        status,
  output logic [RESP_W-1:0] resp0,
  output logic [RESP_W-1:0] resp1
);
  logic done_prev;
  logic done_edge;
  logic take_resp;

  assign done_edge = done_lvl ^ done_prev;
  assign take_resp = done_edge & got_resp;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_prev <= 1'b0;
      req_tgl   <= 1'b0;
      idx_q     <= '0;
      arg_q     <= '0;
      kind_q    <= KIND_NONE;
      busy      <= 1'b0;
      status    <= '0;
      resp0     <= '0;
      resp1     <= '0;
    end else begin
      done_prev <= done_lvl;
      if (start && !busy) begin
        req_tgl <= ~req_tgl;
        idx_q   <= cmd_index;
        arg_q   <= cmd_arg;
        kind_q  <= resp_kind;
        busy    <= 1'b1;
      end
      if (done_edge) busy <= 1'b0;
      status[0] <= (status[0] & ~flag_clr[0]) | done_edge;
      status[1] <= (status[1] & ~flag_clr[1]) | (take_resp & ~crc_match);
      status[2] <= take_resp ? crc_match : status[2];
      status[3] <= (status[3] & ~flag_clr[3]) | (done_edge & timed_out);
      if (take_resp) begin
        resp1 <= rx_frame[KEEP_W-1:RESP_W];
        resp0 <= rx_frame[RESP_W-1:0];
      end
    end
  end

  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_edge |-> busy); // R2
  AST_CRC_FLAG_WITH_BAD: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> !status[2]); // R5
  AST_CRC_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status[1] && !flag_clr[1]) |=> status[1]); // R6
endmodule

// File: rtl/emmc_cmd_engine.sv
module emmc_cmd_engine
  import emmc_cmd_pkg::*;
#(
  parameter int TO_CYC      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        sys_clk,
  input  logic        sys_rst,
  input  logic        emmc_clk,
  input  logic        emmc_rst,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  resp_kind,
  input  logic        start,
  input  logic [3:0]  flag_clr,
  output logic        busy,
  output logic [3:0]  status,
  output logic [63:0] resp0,
  output logic [63:0] resp1,
  output logic        dat0_level,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic        cmd_o,
  output logic        cmd_oe
);
  logic              req_tgl, req_lvl, done_tgl, done_lvl;
  logic [5:0]        idx_q;
  logic [31:0]       arg_q;
  logic [1:0]        kind_q;
  logic              got_resp, crc_match, timed_out;
  logic [KEEP_W-1:0] rx_frame;

  emmc_cmd_regs u_regs (
    .clk(sys_clk), .rst(sys_rst),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .resp_kind(resp_kind),
    .start(start), .flag_clr(flag_clr), .done_lvl(done_lvl),
    .got_resp(got_resp), .crc_match(crc_match), .timed_out(timed_out),
    .rx_frame(rx_frame), .req_tgl(req_tgl), .idx_q(idx_q), .arg_q(arg_q),
    .kind_q(kind_q), .busy(busy), .status(status), .resp0(resp0), .resp1(resp1)
  );

  emmc_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(emmc_clk), .rst(emmc_rst), .d(req_tgl), .q(req_lvl)
  );

  emmc_bit_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(sys_clk), .rst(sys_rst), .d(done_tgl), .q(done_lvl)
  );

  emmc_bit_sync #(.STAGES(SYNC_STAGES)) u_dat0_sync (
    .clk(sys_clk), .rst(sys_rst), .d(dat0_in), .q(dat0_level)
  );

  emmc_cmd_core #(.TO_CYC(TO_CYC)) u_core (
    .clk(emmc_clk), .rst(emmc_rst), .req_lvl(req_lvl),
    .idx(idx_q), .arg(arg_q), .kind(kind_q), .cmd_in(cmd_in),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .done_tgl(done_tgl),
    .got_resp(got_resp), .crc_match(crc_match), .timed_out(timed_out),
    .rx_sh(rx_frame)
  );
endmodule

// File: tb/emmc_cmd_engine_tb.sv
module emmc_cmd_engine_tb_top;
  logic sys_clk = 1'b0, emmc_clk = 1'b0;
  logic sys_rst = 1'b1, emmc_rst = 1'b1;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0]  resp_kind = '0;
  logic        start = 1'b0;
  logic [3:0]  flag_clr = '0;
  logic        busy, dat0_level, cmd_o, cmd_oe;
  logic [3:0]  status;
  logic [63:0] resp0, resp1;
  logic        cmd_in = 1'b1, dat0_in = 1'b1;

  always #2.5 sys_clk = ~sys_clk;
  always #19 emmc_clk = ~emmc_clk;

  emmc_cmd_engine dut_i (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .emmc_clk(emmc_clk), .emmc_rst(emmc_rst),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .resp_kind(resp_kind), .start(start),
    .flag_clr(flag_clr), .busy(busy), .status(status), .resp0(resp0), .resp1(resp1),
    .dat0_level(dat0_level), .cmd_in(cmd_in), .dat0_in(dat0_in),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe)
  );

  typedef struct {
    logic [3:0]  st;
    logic [63:0] r0;
    logic [63:0] r1;
    bit          clr_crc;
    string       rq;
  } exp_t;

  exp_t        expq[$];
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;
  logic        m_if = 0, m_ok = 0;
  logic [63:0] m_r0 = '0, m_r1 = '0;

  task automatic chk(input bit ok, input string rq, input logic [135:0] act,
                     input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [135:0] f, input int hi, input int lo);
    logic [6:0] c;
    c = 7'h00;
    for (int i = hi; i >= lo; i--) begin
      logic m;
      m = c[6] ^ f[i];
      c = {c[5:0], 1'b0};
      if (m) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] ix, input logic [31:0] p,
                                            input bit bad);
    logic [135:0] f;
    f = {88'b0, 2'b00, ix, p, 8'h00};
    f[7:1] = ref_crc(f, 47, 8) ^ (bad ? 7'h01 : 7'h00);
    f[0] = 1'b1;
    return f;
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] p);
    logic [135:0] f;
    f = {2'b00, 6'h3F, p, 8'h00};
    f[7:1] = ref_crc(f, 127, 8);
    f[0] = 1'b1;
    return f;
  endfunction

  // driver: issues one command, plays the device, pushes expectations
  task automatic run_cmd(input logic [5:0] ix, input logic [31:0] ag, input logic [1:0] kd,
                         input bit respond, input logic [135:0] fr, input int dly,
                         input bit clr_crc, input bit dbl, input string rq);
    exp_t it;
    logic [47:0] want, got;
    logic to;
    int nb;
    bit seen;
    want = {2'b01, ix, ag, 8'h00};
    want[7:1] = ref_crc({88'b0, want}, 47, 8);
    want[0] = 1'b1;
    nb = (kd == 2'd2) ? 136 : 48;
    to = (kd == 2'd1 || kd == 2'd2) && !respond;
    if ((kd == 2'd1 || kd == 2'd2) && respond) begin
      m_ok = (ref_crc(fr, (kd == 2'd2) ? 127 : 47, 8) == fr[7:1]);
      if (!m_ok) m_if = 1'b1;
      m_r1 = (kd == 2'd2) ? fr[127:64] : 64'h0;
      m_r0 = (kd == 2'd2) ? fr[63:0] : {16'h0, fr[47:0]};
    end
    it.st = {to, m_ok, m_if, 1'b1};
    it.r0 = m_r0;
    it.r1 = m_r1;
    it.clr_crc = clr_crc;
    it.rq = rq;
    expq.push_back(it);

    @(negedge sys_clk);
    cmd_index = ix; cmd_arg = ag; resp_kind = kd; start = 1'b1;
    @(negedge sys_clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", {135'b0, busy}, 136'h1);
    if (dbl) begin
      @(negedge sys_clk);
      start = 1'b1;
      @(negedge sys_clk);
      start = 1'b0;
    end

    @(negedge emmc_clk);
    while (!cmd_oe) @(negedge emmc_clk);
    for (int i = 47; i >= 0; i--) begin
      got[i] = cmd_o;
      @(negedge emmc_clk);
    end
    chk(got == want, "R1 frame", {88'b0, got}, {88'b0, want});
    chk(cmd_oe == 1'b0, "R1 drive length", {135'b0, cmd_oe}, 136'h0);

    if (respond) begin
      repeat (dly) @(negedge emmc_clk);
      for (int i = nb - 1; i >= 0; i--) begin
        cmd_in = fr[i];
        @(negedge emmc_clk);
      end
      cmd_in = 1'b1;
    end

    while (expq.size() != 0) @(negedge sys_clk);
    repeat (3) @(negedge sys_clk);
    chk(status[0] == 1'b0 && status[3] == 1'b0, "R8 write-1 clear",
        {132'b0, status}, {132'b0, 2'b00, m_if & ~clr_crc, m_ok, 1'b0});
    if (clr_crc) m_if = 1'b0;
    chk(busy == 1'b0, "R2 busy drop", {135'b0, busy}, 136'h0);

    if (dbl) begin
      seen = 0;
      repeat (80) begin
        @(negedge emmc_clk);
        if (cmd_oe) seen = 1;
      end
      chk(!seen, "R2 ignored second start", {135'b0, seen}, 136'h0);
    end
  endtask

  // monitor: pops an expectation on every completion
  initial begin
    exp_t it;
    forever begin
      @(negedge sys_clk);
      if (!sys_rst && status[0] === 1'b1) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected completion", {132'b0, status}, 136'h0);
          flag_clr = 4'b1011;
        end else begin
          it = expq.pop_front();
          chk(status == it.st, it.rq, {132'b0, status}, {132'b0, it.st});
          chk(resp0 == it.r0, "R4 resp0", {72'b0, resp0}, {72'b0, it.r0});
          chk(resp1 == it.r1, "R4 resp1", {72'b0, resp1}, {72'b0, it.r1});
          flag_clr = {1'b1, 1'b0, it.clr_crc, 1'b1};
        end
        @(negedge sys_clk);
        flag_clr = 4'b0000;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!finished) begin
      chk(1'b0, "R2 watchdog expired", 136'h0, 136'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge emmc_clk);
    sys_rst = 1'b0;
    emmc_rst = 1'b0;
    repeat (4) @(negedge sys_clk);
    // R10 reset state
    chk(status == 4'h0 && busy == 1'b0 && cmd_oe == 1'b0, "R10 reset flags",
        {131'b0, cmd_oe, busy, status}, 136'h0);
    chk(resp0 == 64'h0 && resp1 == 64'h0, "R10 reset responses",
        {resp1, resp0}, 136'h0);

    // R3 no response; R1 known frame tail 0x95
    run_cmd(6'd0, 32'h0, 2'd0, 0, '0, 0, 0, 0, "R3 no-response status");
    chk(ref_crc({88'b0, 2'b01, 6'd0, 32'h0, 8'h00}, 47, 8) == 7'h4A, "R1 crc constant",
        136'h0, 136'h4A);
    // R3/R4/R5 good short response
    run_cmd(6'd17, 32'h0000_1234, 2'd1, 1, mk_short(6'd17, 32'h0000_0900, 0), 2, 0, 0,
            "R5 good short status");
    // R5 bad CRC, flag kept
    run_cmd(6'd13, 32'hA5A5_0001, 2'd1, 1, mk_short(6'd13, 32'hDEAD_BEEF, 1), 3, 0, 0,
            "R5 bad crc status");
    // R6 fixed-ones response still flagged, flag kept
    run_cmd(6'd1, 32'h40FF_8080, 2'd1, 1, {88'b0, 2'b00, 6'h3F, 32'hC0FF_8080, 7'h7F, 1'b1},
            2, 0, 0, "R6 fixed-field status");
    // R6 flag survives a good response, then cleared
    run_cmd(6'd7, 32'h0001_0000, 2'd1, 1, mk_short(6'd7, 32'h0000_0700, 0), 4, 1, 0,
            "R6 sticky across good");
    run_cmd(6'd16, 32'h0000_0200, 2'd1, 1, mk_short(6'd16, 32'h0000_0900, 0), 2, 0, 0,
            "R6 cleared then good");
    // R4 long response
    run_cmd(6'd2, 32'h0, 2'd2, 1, mk_long(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32), 5, 0, 0,
            "R3 long status");
    // R7 timeout keeps registers
    run_cmd(6'd9, 32'h0002_0000, 2'd1, 0, '0, 0, 0, 0, "R7 timeout status");
    // R2 second start while busy ignored
    run_cmd(6'd0, 32'h0, 2'd0, 0, '0, 0, 0, 1, "R2 single completion");
    // R9 busy polling after a response with busy
    run_cmd(6'd6, 32'h03B7_0100, 2'd1, 1, mk_short(6'd6, 32'h0000_0800, 0), 2, 0, 0,
            "R5 busy-type status");
    dat0_in = 1'b0;
    repeat (3) @(negedge sys_clk);
    chk(dat0_level == 1'b0, "R9 dat0 low", {135'b0, dat0_level}, 136'h0);
    dat0_in = 1'b1;
    repeat (3) @(negedge sys_clk);
    chk(dat0_level == 1'b1, "R9 dat0 high", {135'b0, dat0_level}, 136'h1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule